// File: doc/BRIEF.md
# Bit-Serial Instruction Fetch Unit

This block reads instruction words from a bit-addressed memory one bit per clock. A 10-bit program counter names the word. A free-running bit-period counter names the bit within that word. Together they form a 15-bit memory address. Each returned bit enters an 18-bit shift register, least-significant bit first.

On the last bit period of a fetch, the upper 17 bits of the shift register are copied into a 17-bit instruction register, and the program counter steps to the next word. This copy happens one period before the final bit arrives. The instruction register is split into three fields for the rest of the machine:

- a one-bit length flag,
- a 10-bit operand address,
- a 5-bit opcode.

When the address-select control is raised, the operand address field takes the place of the program counter in the word part of the memory address.

Top module: `bitser_fetch`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the bit counter, the shift register and the instruction register. While reset holds, `mem_addr_o` is 0 and every decoded field is 0.
- R2: The bit counter advances on every clock from 0 to 17 and then returns to 0. It drives `mem_addr_o[4:0]`.
- R3: `mem_addr_o[14:5]` carries the program counter when `addr_sel_i`=0 and the operand address field when `addr_sel_i`=1.
- R4: When `shift_en_i`=1, the read bit enters shift-register bit 17 and the other bits move one place toward bit 0. When `shift_en_i`=0, the register holds. A later capture then sees the unshifted contents.
- R5: On a clock where `fetch_i`=1 and the bit counter is 17, the instruction register loads shift-register bits 17..1. After a full 18-period fetch with shifting enabled, it holds word bits 16..0.
- R6: On any other clock, the instruction register keeps its value.
- R7: On a clock where `fetch_i`=1 and the bit counter is 17, the program counter increments, and it wraps from 1023 to 0.
- R8: `pc_load_i`=1 loads `pc_load_val_i` into the program counter on the next edge. This load wins over an increment on the same edge.
- R9: Field decode is `word_len_o` = instruction bit 0, `oper_addr_o` = bits 10..1 and `opcode_o` = bits 16..12. Bit 11 reaches no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fetch_i | input | 1 | Fetch cycle in progress |
| addr_sel_i | input | 1 | Word address source: 0 program counter, 1 operand field |
| shift_en_i | input | 1 | Shift the read bit into the shift register |
| pc_load_i | input | 1 | Load the program counter |
| pc_load_val_i | input | 10 | Program counter load value |
| mem_rd_bit_i | input | 1 | Serial bit read from memory |
| mem_addr_o | output | 15 | Memory address: word in 14..5, bit in 4..0 |
| word_len_o | output | 1 | Length field |
| oper_addr_o | output | 10 | Operand address field |
| opcode_o | output | 5 | Opcode field |

## Verification
Directed fetches of known words at program counter 0 show whether the captured word is aligned with the memory word or off by one bit. A second fetch with shifting disabled tells a held register from one that keeps shifting. A load of 1023 followed by a fetch separates a 10-bit wrap from a wider counter. A load on the same edge as a capture shows which of load and increment wins. Long seeded random runs mix fetch, select, shift and load to reach the other orderings. A bench model is compared against the address and the fields on every clock.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   // Default geometry of the fetch path
   localparam int unsigned DEF_WORD_BITS = 18;
   localparam int unsigned DEF_PC_W      = 10;
   localparam int unsigned DEF_OPC_LSB   = 12;
   localparam int unsigned DEF_OPC_W     = 5;

   // Source of the word part of the memory address
   typedef enum logic {
      WSRC_PC   = 1'b0,
      WSRC_OPER = 1'b1
   } word_src_e;

   // Ceiling log2 helper with a floor of one bit
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/fetch_bitctr.sv
module fetch_bitctr #(
   parameter int unsigned PERIODS = 18,
   parameter int unsigned CNT_W   = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIODS - 1);

   logic [CNT_W-1:0] cnt_q;

   if (PERIODS < 2) begin : g_bad_periods
      $error("fetch_bitctr: PERIODS must be at least 2");
   end
   if ((1 << CNT_W) < PERIODS) begin : g_bad_width
      $error("fetch_bitctr: CNT_W too narrow for PERIODS");
   end

   if ((1 << CNT_W) == PERIODS) begin : g_natural_wrap
      // Power-of-two period count: the adder wraps by itself
      always_ff @(posedge clk_i) begin
         if (rst_i) cnt_q <= '0;
         else       cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_compare_wrap
      always_ff @(posedge clk_i) begin
         if (rst_i)              cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc #(
   parameter int unsigned PC_W = 10
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            load_i,
   input  logic [PC_W-1:0] load_val_i,
   input  logic            step_i,
   output logic [PC_W-1:0] pc_o
);

   logic [PC_W-1:0] pc_q;

   if (PC_W < 1) begin : g_bad_pc
      $error("fetch_pc: PC_W must be positive");
   end

   // Load wins over step; the step wraps at the counter width
   always_ff @(posedge clk_i) begin
      if (rst_i)       pc_q <= '0;
      else if (load_i) pc_q <= load_val_i;
      else if (step_i) pc_q <= pc_q + 1'b1;
   end

   assign pc_o = pc_q;

endmodule

// File: rtl/fetch_sreg.sv
module fetch_sreg #(
   parameter int unsigned WORD_BITS = 18
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 shift_i,
   input  logic                 bit_i,
   output logic [WORD_BITS-1:0] q_o
);

   logic [WORD_BITS-1:0] q;

   if (WORD_BITS < 2) begin : g_bad_len
      $error("fetch_sreg: WORD_BITS must be at least 2");
   end

   // New bit enters at the top; older bits move toward bit 0
   always_ff @(posedge clk_i) begin
      if (rst_i)        q <= '0;
      else if (shift_i) q <= {bit_i, q[WORD_BITS-1:1]};
   end

   assign q_o = q;

endmodule

// File: rtl/fetch_ir.sv
module fetch_ir #(
   parameter int unsigned IR_W    = 17,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned OPC_LSB = 12,
   parameter int unsigned OPC_W   = 5
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [IR_W-1:0]   d_i,
   output logic [IR_W-1:0]   ir_o,
   output logic              len_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [OPC_W-1:0]  opc_o
);

   localparam int unsigned ADDR_LSB = 1;
   localparam int unsigned ADDR_MSB = ADDR_LSB + ADDR_W - 1;
   localparam int unsigned OPC_MSB  = OPC_LSB + OPC_W - 1;

   if (OPC_MSB >= IR_W) begin : g_bad_opc
      $error("fetch_ir: opcode field exceeds the register");
   end
   if (OPC_LSB <= ADDR_MSB) begin : g_bad_overlap
      $error("fetch_ir: opcode field overlaps the address field");
   end

   logic [IR_W-1:0] ir_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       ir_q <= '0;
      else if (load_i) ir_q <= d_i;
   end

   assign ir_o   = ir_q;
   assign len_o  = ir_q[0];
   assign addr_o = ir_q[ADDR_MSB:ADDR_LSB];
   assign opc_o  = ir_q[OPC_MSB:OPC_LSB];

endmodule

// File: rtl/bitser_fetch.sv
module bitser_fetch
   import fetch_pkg::*;
#(
   parameter int unsigned WORD_BITS = DEF_WORD_BITS,
   parameter int unsigned PC_W      = DEF_PC_W,
   parameter int unsigned OPC_LSB   = DEF_OPC_LSB,
   parameter int unsigned OPC_W     = DEF_OPC_W,
   parameter int unsigned BIT_W     = bits_for(DEF_WORD_BITS),
   parameter int unsigned MA_W      = DEF_PC_W + bits_for(DEF_WORD_BITS)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              fetch_i,
   input  logic              addr_sel_i,
   input  logic              shift_en_i,
   input  logic              pc_load_i,
   input  logic [PC_W-1:0]   pc_load_val_i,
   input  logic              mem_rd_bit_i,
   output logic [MA_W-1:0]   mem_addr_o,
   output logic              word_len_o,
   output logic [PC_W-1:0]   oper_addr_o,
   output logic [OPC_W-1:0]  opcode_o
);

   // Capture is one period early, so the register is one bit shorter
   localparam int unsigned IR_W = WORD_BITS - 1;

   if (MA_W != PC_W + BIT_W) begin : g_bad_ma
      $error("bitser_fetch: MA_W must equal PC_W + BIT_W");
   end
   if ((1 << BIT_W) < WORD_BITS) begin : g_bad_bitw
      $error("bitser_fetch: BIT_W cannot index every bit of a word");
   end

   logic [BIT_W-1:0]     bit_cnt;
   logic                 last_period;
   logic [PC_W-1:0]      pc;
   logic [WORD_BITS-1:0] sreg;
   logic [IR_W-1:0]      ir;
   logic                 capture;
   word_src_e            wsrc;
   logic [PC_W-1:0]      word_sel;

   assign capture = fetch_i & last_period;
   assign wsrc    = word_src_e'(addr_sel_i);

   fetch_bitctr #(
      .PERIODS (WORD_BITS),
      .CNT_W   (BIT_W)
   ) u_bitctr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .cnt_o  (bit_cnt),
      .last_o (last_period)
   );

   fetch_pc #(
      .PC_W (PC_W)
   ) u_pc (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (pc_load_i),
      .load_val_i (pc_load_val_i),
      .step_i     (capture),
      .pc_o       (pc)
   );

   fetch_sreg #(
      .WORD_BITS (WORD_BITS)
   ) u_sreg (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .shift_i (shift_en_i),
      .bit_i   (mem_rd_bit_i),
      .q_o     (sreg)
   );

   fetch_ir #(
      .IR_W    (IR_W),
      .ADDR_W  (PC_W),
      .OPC_LSB (OPC_LSB),
      .OPC_W   (OPC_W)
   ) u_ir (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (capture),
      .d_i    (sreg[WORD_BITS-1:1]),
      .ir_o   (ir),
      .len_o  (word_len_o),
      .addr_o (oper_addr_o),
      .opc_o  (opcode_o)
   );

   always_comb begin
      unique case (wsrc)
         WSRC_OPER: word_sel = oper_addr_o;
         default:   word_sel = pc;
      endcase
   end

   assign mem_addr_o = {word_sel, bit_cnt};

endmodule

// File: rtl/bitser_fetch_chk.sv
module bitser_fetch_chk #(
   parameter int unsigned WORD_BITS = 18,
   parameter int unsigned PC_W      = 10,
   parameter int unsigned BIT_W     = 5
) (
   input logic                 clk_i,
   input logic                 rst_i,
   input logic                 fetch_i,
   input logic                 shift_en_i,
   input logic                 pc_load_i,
   input logic [PC_W-1:0]      pc_load_val_i,
   input logic                 mem_rd_bit_i,
   input logic [BIT_W-1:0]     bit_cnt,
   input logic [PC_W-1:0]      pc,
   input logic [WORD_BITS-1:0] sreg,
   input logic [WORD_BITS-2:0] ir
);

   localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_BITS - 1);

   p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      bit_cnt <= LAST);

   p_cnt_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (bit_cnt == LAST) |=> (bit_cnt == '0));

   p_shift_move_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      shift_en_i |=> (sreg == {$past(mem_rd_bit_i), $past(sreg[WORD_BITS-1:1])}));

   p_shift_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !shift_en_i |=> $stable(sreg));

   p_ir_capture_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (fetch_i && bit_cnt == LAST) |=> (ir == $past(sreg[WORD_BITS-1:1])));

   p_ir_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !(fetch_i && bit_cnt == LAST) |=> $stable(ir));

   p_pc_step_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (fetch_i && bit_cnt == LAST && !pc_load_i) |=> (pc == $past(pc) + 1'b1));

   p_pc_load_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      pc_load_i |=> (pc == $past(pc_load_val_i)));

endmodule

bind bitser_fetch bitser_fetch_chk #(
   .WORD_BITS (WORD_BITS),
   .PC_W      (PC_W),
   .BIT_W     (BIT_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .fetch_i       (fetch_i),
   .shift_en_i    (shift_en_i),
   .pc_load_i     (pc_load_i),
   .pc_load_val_i (pc_load_val_i),
   .mem_rd_bit_i  (mem_rd_bit_i),
   .bit_cnt       (bit_cnt),
   .pc            (pc),
   .sreg          (sreg),
   .ir            (ir)
);

// File: tb/bitser_fetch_bench.sv
module bitser_fetch_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        fetch, asel, shen, pcld;
   logic [9:0]  pcval;
   logic        mbit;
   logic [14:0] maddr;
   logic        len;
   logic [9:0]  oaddr;
   logic [4:0]  opc;

   logic [17:0] mem [1024];

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Bench model state
   int unsigned m_cnt;
   logic [9:0]  m_pc;
   logic [17:0] m_sr;
   logic [16:0] m_ir;

   always #10 clk = ~clk;

   assign mbit = mem[maddr[14:5]][maddr[4:0]];

   bitser_fetch u_bitser_fetch (
      .clk_i         (clk),
      .rst_i         (rst),
      .fetch_i       (fetch),
      .addr_sel_i    (asel),
      .shift_en_i    (shen),
      .pc_load_i     (pcld),
      .pc_load_val_i (pcval),
      .mem_rd_bit_i  (mbit),
      .mem_addr_o    (maddr),
      .word_len_o    (len),
      .oper_addr_o   (oaddr),
      .opcode_o      (opc)
   );

   function automatic logic [14:0] exp_addr();
      logic [9:0] w;
      w = asel ? m_ir[10:1] : m_pc;
      return {w, 5'(m_cnt)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      logic [14:0] ea;
      ea = exp_addr();
      chk("R2 bit counter", 32'(maddr[4:0]), 32'(ea[4:0]));
      chk("R3 word address", 32'(maddr[14:5]), 32'(ea[14:5]));
      chk("R9 length field", 32'(len), 32'(m_ir[0]));
      chk("R9 operand field", 32'(oaddr), 32'(m_ir[10:1]));
      chk("R9 opcode field", 32'(opc), 32'(m_ir[16:12]));
   endtask

   // One clock with the present inputs; model advances, outputs compared
   task automatic step();
      logic [14:0] a;
      logic        b, cap;
      a   = exp_addr();
      b   = mem[a[14:5]][a[4:0]];
      cap = fetch && (m_cnt == 17);
      @(posedge clk);
      if (cap) m_ir = m_sr[17:1];
      if (shen) m_sr = {b, m_sr[17:1]};
      if (pcld)     m_pc = pcval;
      else if (cap) m_pc = m_pc + 10'd1;
      m_cnt = (m_cnt == 17) ? 0 : m_cnt + 1;
      @(negedge clk);
      check_all();
   endtask

   task automatic set_in(input logic f, input logic s, input logic sh,
                         input logic l, input logic [9:0] v);
      fetch = f; asel = s; shen = sh; pcld = l; pcval = v;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      set_in(0, 0, 0, 0, 10'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      m_cnt = 0; m_pc = '0; m_sr = '0; m_ir = '0;
      chk("R1 reset address", 32'(maddr), 32'd0);
      chk("R1 reset fields", {len, oaddr, opc}, 32'd0);
      rst = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd7341));
      for (int i = 0; i < 1024; i++) mem[i] = 18'($urandom);
      mem[0] = 18'b10_1101_0_1100110011_1;
      mem[1] = 18'b01_0011_1_0101010101_0;
      @(negedge clk);
      do_reset();

      // Full fetch of word 0 from counter 0
      set_in(1, 0, 1, 0, 10'd0);
      for (int i = 0; i < 18; i++) step();
      chk("R5 captured word", {len, oaddr, opc},
          {mem[0][0], mem[0][10:1], mem[0][16:12]});
      chk("R7 pc after fetch", 32'(maddr[14:5]), 32'd1);

      // Shifting off: next capture sees the unshifted word 0, bits 17..1
      set_in(1, 0, 0, 0, 10'd0);
      for (int i = 0; i < 18; i++) step();
      chk("R4 hold then capture", {oaddr, opc},
          {mem[0][11:2], mem[0][17:13]});

      // Wrap of the program counter from 1023
      set_in(0, 0, 1, 1, 10'd1023);
      step();
      set_in(1, 0, 1, 0, 10'd0);
      while (m_cnt != 0) step();
      chk("R7 pc wrap", 32'(maddr[14:5]), 32'd0);

      // Load on the capture edge wins over the increment
      set_in(1, 0, 1, 0, 10'd0);
      while (m_cnt != 17) step();
      set_in(1, 0, 1, 1, 10'd300);
      step();
      chk("R8 load priority", 32'(maddr[14:5]), 32'd300);

      // No fetch: register must hold across a last period
      set_in(0, 1, 1, 0, 10'd0);
      for (int i = 0; i < 20; i++) step();

      // Seeded random mix
      for (int i = 0; i < 6000; i++) begin
         set_in(($urandom % 8) != 0, ($urandom % 4) == 0, ($urandom % 6) != 0,
                ($urandom % 40) == 0, 10'($urandom));
         step();
         if ((i % 2500) == 2499) begin
            rst = 1'b1; step_reset_model();
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic step_reset_model();
      @(posedge clk);
      @(negedge clk);
      m_cnt = 0; m_pc = '0; m_sr = '0; m_ir = '0;
      chk("R1 mid-run reset", 32'(maddr), 32'd0);
      rst = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule